// File: doc/BRIEF.md
# Contiguous Slot Bitmap Allocator

This block hands out runs of adjacent slots from a small pool of fixed-size storage slots. The slots hold a coprocessor's local key and context data. Each slot has one occupancy bit. A single request port accepts three operations, one at a time, under a valid/ready handshake:

- **Allocate** looks for the first run of free slots that is long enough.
- **Free** releases a run that was allocated earlier.
- **Reserve** takes one slot for a command queue's private use during bring-up. A queue normally issues two reserves, one for its key slot and one for its context slot.

Every request gets exactly one response. The response carries a status bit and a slot index. Indices on the port are offset by a fixed base constant, so index zero never names a real slot.

The allocate search is first-fit, with no alignment constraint on the run. It tests one slot per clock cycle and starts at a movable low-water start index. Each reservation moves the start index up by one and moves the upper end of the searchable window down by one.

A separate availability flag drops when an allocation cannot be satisfied. Only a later successful free raises it again, so a waiting requester knows when retrying is worthwhile.

Top module: `slotpool_alloc`

## Requirements
- R1: After reset the following hold:
  - every slot is free;
  - the start index is 0 and the window end is NUM_SLOTS;
  - `slots_avail` is 1, `req_ready` is 1 and `rsp_valid` is 0.
- R2: An allocate (`req_op` = 2'b00) with count c finds the lowest run of c consecutive free slots. The run lies inside the window between the start index and the window end, with no alignment constraint. All c slots become occupied, and the response has `rsp_ok`=1 and `rsp_index` = BASE_OFFSET + run position.
- R3: An allocate that finds no run before the window end responds with `rsp_ok`=0 and clears `slots_avail`.
- R4: An allocate with count 0 fails at once and leaves `slots_avail` unchanged. An allocate whose count exceeds the window size fails at once, without scanning, and clears `slots_avail`.
- R5: A free (`req_op` = 2'b01) with index i and count c releases the c slots starting at position i - BASE_OFFSET. It responds with `rsp_ok`=1 and `rsp_index`=i, and sets `slots_avail`.
- R6: The following frees are ignored: index 0, index below BASE_OFFSET, or count 0. An ignored free changes no slot and leaves `slots_avail` unchanged, and it responds with `rsp_ok`=0.
- R7: A reserve (`req_op` = 2'b10) works as follows while the start index is below the window end:
  - it returns `rsp_ok`=1 and `rsp_index` = BASE_OFFSET + start index;
  - it raises the start index by one and lowers the window end by one.
  Otherwise the reserve fails and nothing changes.
- R8: The search tests one slot per cycle. Requests are serialized, so `req_ready` stays 0 while a search runs. An allocate of c slots at the start of an empty window therefore responds c cycles after acceptance. Every response is a one-cycle `rsp_valid` pulse.
- R9: `req_op` = 2'b11 is rejected with `rsp_ok`=0 and changes neither the slots nor `slots_avail`.
- R10: Every failed response carries `rsp_index`=0, and every successful response carries `rsp_index` >= BASE_OFFSET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_op | input | 2 | 00 allocate, 01 free, 10 reserve, 11 invalid |
| req_count | input | $clog2(NUM_SLOTS+1) | Run length for allocate or free |
| req_index | input | IDX_W | Offset slot index for free |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | Request succeeded |
| rsp_index | output | IDX_W | Offset index of the run or reserved slot; 0 on failure |
| slots_avail | output | 1 | Cleared on allocation failure, set by a successful free |

## Verification
The bound checker watches the following on every cycle:
- a failed response always carries index zero, and a successful one never carries an index below the offset;
- no response appears while a search holds `req_ready` low;
- every response follows an accepted request or a finished search;
- `slots_avail` falls only together with a failed response and rises only after an accepted free.

First-fit placement, run reuse after a free, the one-slot-per-cycle latency, and the movement of the start index and window end cannot be checked this way, because the occupancy map is internal. The bench shows them through sequences of requests whose returned indices reveal the slot state.

// File: rtl/slotpool_pkg.sv
package slotpool_pkg;

    typedef enum logic [1:0] {
        OP_ALLOC   = 2'b00,
        OP_FREE    = 2'b01,
        OP_RESERVE = 2'b10,
        OP_INVALID = 2'b11
    } slot_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } slot_state_e;

    // True when slot position pos lies in the run [lo, lo+cnt)
    function automatic logic in_run(input int pos, input int lo, input int cnt);
        return (pos >= lo) && (pos < lo + cnt);
    endfunction

endpackage

// File: rtl/slotpool_map.sv
module slotpool_map #(
    parameter int NUM_SLOTS = 16,
    parameter int POS_W     = 5,
    parameter int LO_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [LO_W-1:0]  run_lo,
    input  logic [POS_W-1:0] run_cnt,
    input  logic [POS_W-1:0] rd_pos,
    output logic             rd_busy
);
    import slotpool_pkg::*;

    localparam int SEL_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic [NUM_SLOTS-1:0] occ_q;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic hit;
        assign hit = in_run(g, int'(run_lo), int'(run_cnt));
        always_ff @(posedge clk) begin
            if (rst) begin
                occ_q[g] <= 1'b0;
            end else if (set_en && hit) begin
                occ_q[g] <= 1'b1;
            end else if (clr_en && hit) begin
                occ_q[g] <= 1'b0;
            end
        end
    end

    // Positions past the pool read as occupied
    assign rd_busy = (rd_pos < POS_W'(NUM_SLOTS)) ? occ_q[rd_pos[SEL_W-1:0]] : 1'b1;

endmodule

// File: rtl/slotpool_scan.sv
module slotpool_scan #(
    parameter int POS_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [POS_W-1:0] lo,
    input  logic [POS_W-1:0] lim,
    input  logic [POS_W-1:0] need,
    input  logic             cur_busy,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] run_base,
    output logic             found,
    output logic             exhausted
);
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] run_q;
    logic [POS_W:0]   run_next;

    assign run_next  = {1'b0, run_q} + 1'b1;
    assign exhausted = (pos_q >= lim);
    assign found     = !exhausted && !cur_busy && (run_next == {1'b0, need});
    assign run_base  = pos_q + 1'b1 - need;
    assign pos       = pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            run_q <= '0;
        end else if (load) begin
            pos_q <= lo;
            run_q <= '0;
        end else if (step) begin
            pos_q <= pos_q + 1'b1;
            run_q <= cur_busy ? '0 : run_next[POS_W-1:0];
        end
    end

endmodule

// File: rtl/slotpool_alloc.sv
module slotpool_alloc #(
    parameter int NUM_SLOTS   = 16,
    parameter int BASE_OFFSET = 4,
    parameter int IDX_W       = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               req_valid,
    output logic                               req_ready,
    input  logic [1:0]                         req_op,
    input  logic [$clog2(NUM_SLOTS+1)-1:0]     req_count,
    input  logic [IDX_W-1:0]                   req_index,
    output logic                               rsp_valid,
    output logic                               rsp_ok,
    output logic [IDX_W-1:0]                   rsp_index,
    output logic                               slots_avail
);
    import slotpool_pkg::*;

    localparam int POS_W = $clog2(NUM_SLOTS + 1);
    localparam logic [IDX_W-1:0] BASE = IDX_W'(BASE_OFFSET);

    slot_state_e      state_q;
    logic [POS_W-1:0] start_q, lim_q, cnt_q, span;
    logic             avail_q;
    logic             fire, scan_load, scan_step, free_ok;
    logic             set_en, cur_busy, found, exhausted;
    logic [POS_W-1:0] scan_pos, run_base;
    logic [IDX_W-1:0] free_lo, map_lo;
    logic [POS_W-1:0] map_cnt;
    slot_op_e         op;

    assign op        = slot_op_e'(req_op);
    assign req_ready = (state_q == ST_IDLE);
    assign fire      = req_valid && req_ready;
    assign span      = lim_q - start_q;
    assign free_lo   = req_index - BASE;
    assign free_ok   = fire && (op == OP_FREE) && (req_index != '0)
                       && (req_index >= BASE) && (req_count != '0);
    assign scan_load = fire && (op == OP_ALLOC) && (req_count != '0)
                       && (req_count <= span);
    assign scan_step = (state_q == ST_SCAN) && !found && !exhausted;
    assign set_en    = (state_q == ST_SCAN) && found;
    assign map_lo    = set_en ? IDX_W'(run_base) : free_lo;
    assign map_cnt   = set_en ? cnt_q : req_count;

    slotpool_map #(.NUM_SLOTS(NUM_SLOTS), .POS_W(POS_W), .LO_W(IDX_W)) map_i (
        .clk(clk), .rst(rst), .set_en(set_en), .clr_en(free_ok),
        .run_lo(map_lo), .run_cnt(map_cnt), .rd_pos(scan_pos), .rd_busy(cur_busy)
    );

    slotpool_scan #(.POS_W(POS_W)) scan_i (
        .clk(clk), .rst(rst), .load(scan_load), .step(scan_step),
        .lo(start_q), .lim(lim_q), .need(cnt_q), .cur_busy(cur_busy),
        .pos(scan_pos), .run_base(run_base), .found(found), .exhausted(exhausted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            start_q   <= '0;
            lim_q     <= POS_W'(NUM_SLOTS);
            cnt_q     <= '0;
            avail_q   <= 1'b1;
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_index <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_index <= '0;
            case (state_q)
                ST_IDLE: begin
                    if (fire) begin
                        case (op)
                            OP_ALLOC: begin
                                if (scan_load) begin
                                    state_q <= ST_SCAN;
                                    cnt_q   <= req_count;
                                end else begin
                                    rsp_valid <= 1'b1;
                                    if (req_count != '0) avail_q <= 1'b0;
                                end
                            end
                            OP_FREE: begin
                                rsp_valid <= 1'b1;
                                if (free_ok) begin
                                    rsp_ok    <= 1'b1;
                                    rsp_index <= req_index;
                                    avail_q   <= 1'b1;
                                end
                            end
                            OP_RESERVE: begin
                                rsp_valid <= 1'b1;
                                if (start_q < lim_q) begin
                                    rsp_ok    <= 1'b1;
                                    rsp_index <= BASE + IDX_W'(start_q);
                                    start_q   <= start_q + 1'b1;
                                    lim_q     <= lim_q - 1'b1;
                                end
                            end
                            default: rsp_valid <= 1'b1;
                        endcase
                    end
                end
                ST_SCAN: begin
                    if (exhausted) begin
                        state_q   <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        avail_q   <= 1'b0;
                    end else if (found) begin
                        state_q   <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_ok    <= 1'b1;
                        rsp_index <= BASE + IDX_W'(run_base);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign slots_avail = avail_q;

endmodule

// File: rtl/slotpool_alloc_chk.sv
module slotpool_alloc_chk #(
    parameter int BASE_OFFSET = 4,
    parameter int IDX_W       = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_op,
    input logic             rsp_valid,
    input logic             rsp_ok,
    input logic [IDX_W-1:0] rsp_index,
    input logic             slots_avail
);
    // R10
    fail_index_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ok) |-> (rsp_index == '0));

    // R10
    ok_index_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ok) |-> (rsp_index >= IDX_W'(BASE_OFFSET)));

    // R8
    no_rsp_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> !rsp_valid);

    // R8
    rsp_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(!req_ready)));

    // R5
    avail_rise_on_free_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(slots_avail) |-> $past(req_valid && req_ready && req_op == 2'b01));

    // R3
    avail_fall_on_fail_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(slots_avail) |-> (rsp_valid && !rsp_ok));

endmodule

bind slotpool_alloc slotpool_alloc_chk #(.BASE_OFFSET(BASE_OFFSET), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/slotpool_alloc_tb.sv
module slotpool_alloc_tb_top;

    localparam int NS = 16;
    localparam int BO = 4;
    localparam int IW = 8;
    localparam int PW = $clog2(NS + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'b00;
    logic [PW-1:0] req_count = '0;
    logic [IW-1:0] req_index = '0;
    logic          rsp_valid, rsp_ok, slots_avail;
    logic [IW-1:0] rsp_index;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    slotpool_alloc #(.NUM_SLOTS(NS), .BASE_OFFSET(BO), .IDX_W(IW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_count(req_count), .req_index(req_index),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_index(rsp_index),
        .slots_avail(slots_avail)
    );

    // {op[24:23], count[22:18], index[17:10], exp_ok[9], exp_index[8:1], exp_avail[0]}
    localparam logic [24:0] VEC [14] = '{
        {2'd2, 5'd0,  8'd0, 1'b1, 8'd4,  1'b1},  // R7 reserve key
        {2'd2, 5'd0,  8'd0, 1'b1, 8'd5,  1'b1},  // R7 reserve ctx
        {2'd0, 5'd3,  8'd0, 1'b1, 8'd6,  1'b1},  // R2
        {2'd0, 5'd2,  8'd0, 1'b1, 8'd9,  1'b1},  // R2
        {2'd0, 5'd4,  8'd0, 1'b1, 8'd11, 1'b1},  // R2
        {2'd1, 5'd2,  8'd9, 1'b1, 8'd9,  1'b1},  // R5
        {2'd0, 5'd3,  8'd0, 1'b1, 8'd15, 1'b1},  // R2 skips short hole
        {2'd0, 5'd2,  8'd0, 1'b1, 8'd9,  1'b1},  // R2 first fit
        {2'd0, 5'd1,  8'd0, 1'b0, 8'd0,  1'b0},  // R3
        {2'd1, 5'd1,  8'd0, 1'b0, 8'd0,  1'b0},  // R6 index zero
        {2'd1, 5'd3,  8'd6, 1'b1, 8'd6,  1'b1},  // R5
        {2'd0, 5'd0,  8'd0, 1'b0, 8'd0,  1'b1},  // R4 zero count
        {2'd0, 5'd13, 8'd0, 1'b0, 8'd0,  1'b0},  // R4 oversize
        {2'd0, 5'd3,  8'd0, 1'b1, 8'd6,  1'b0}   // R2 reuse
    };

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Issue one request; report response, cycles to response, busy after accept
    task automatic do_req(input logic [1:0] op, input int cnt, input int idx,
                          output logic ok, output int ridx, output int lat,
                          output logic busy_seen);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_count = PW'(cnt);
        req_index = IW'(idx);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy_seen = !req_ready;
        lat = 0;
        while (!rsp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        ok   = rsp_ok;
        ridx = int'(rsp_index);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic ok, busy;
        int   ridx, lat;

        do_reset();
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        check(slots_avail == 1'b1, "R1 avail", int'(slots_avail), 1);

        for (int i = 0; i < 14; i++) begin
            do_req(VEC[i][24:23], int'(VEC[i][22:18]), int'(VEC[i][17:10]), ok, ridx, lat, busy);
            check(ok == VEC[i][9], $sformatf("vec%0d ok", i), int'(ok), int'(VEC[i][9]));
            check(ridx == int'(VEC[i][8:1]), $sformatf("vec%0d index", i), ridx, int'(VEC[i][8:1]));
            check(slots_avail == VEC[i][0], $sformatf("vec%0d avail", i),
                  int'(slots_avail), int'(VEC[i][0]));
        end

        // R8 whole pool, one slot per cycle, busy while scanning, one-cycle pulse
        do_reset();
        do_req(2'd0, 16, 0, ok, ridx, lat, busy);
        check(ok && ridx == 4, "R2 full pool index", ridx, 4);
        check(lat == 16, "R8 latency", lat, 16);
        check(busy, "R8 ready low during scan", int'(busy), 1);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8 pulse width", int'(rsp_valid), 0);

        // R3 scan to end with nothing free
        do_req(2'd0, 1, 0, ok, ridx, lat, busy);
        check(!ok && ridx == 0, "R3 full fail", ridx, 0);
        check(slots_avail == 1'b0, "R3 avail cleared", int'(slots_avail), 0);

        // R9 invalid op
        do_req(2'd3, 1, 4, ok, ridx, lat, busy);
        check(!ok, "R9 rejected", int'(ok), 0);
        check(slots_avail == 1'b0, "R9 avail untouched", int'(slots_avail), 0);
        do_req(2'd0, 1, 0, ok, ridx, lat, busy);
        check(!ok, "R9 pool still full", int'(ok), 0);

        // R5 release all, then whole pool is usable again
        do_req(2'd1, 16, 4, ok, ridx, lat, busy);
        check(ok && ridx == 4, "R5 free all", ridx, 4);
        check(slots_avail == 1'b1, "R5 avail set", int'(slots_avail), 1);
        do_req(2'd0, 16, 0, ok, ridx, lat, busy);
        check(ok && ridx == 4, "R5 realloc all", ridx, 4);

        // R6 index below offset, count zero
        do_req(2'd1, 4, 2, ok, ridx, lat, busy);
        check(!ok, "R6 below offset", int'(ok), 0);
        do_req(2'd1, 0, 4, ok, ridx, lat, busy);
        check(!ok, "R6 zero count", int'(ok), 0);
        do_req(2'd0, 1, 0, ok, ridx, lat, busy);
        check(!ok, "R6 slots still held", int'(ok), 0);

        // R7 reserve until window closes
        do_reset();
        for (int k = 0; k < 8; k++) begin
            do_req(2'd2, 0, 0, ok, ridx, lat, busy);
            check(ok && ridx == BO + k, "R7 reserve", ridx, BO + k);
        end
        do_req(2'd2, 0, 0, ok, ridx, lat, busy);
        check(!ok && ridx == 0, "R7 window empty", ridx, 0);
        do_req(2'd0, 1, 0, ok, ridx, lat, busy);
        check(!ok && lat == 0, "R4 empty window immediate", lat, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule